// File: doc/BRIEF.md
# JTAG Boundary-Scan Test Access Port

This block is a JTAG test access port for a chip that has no dedicated test-reset pin. A 16-state controller steps on TMS at each rising edge of TCK. A 4-bit instruction register selects one of three data paths between TDI and TDO: a single bypass bit, a 32-bit identification register, or a boundary chain.

The boundary chain has two kinds of cell. Each pad cell observes the pad input, the core's output value and the core's output enable. It also holds update stages for the value and the enable, so that the pad can be driven from the scan path. Each logic cell observes one internal signal and has only capture and shift stages. A power-on reset forces the controller into Test-Logic-Reset and selects the identification register.

Under EXTEST the pads take their value and enable from the update stages. Under HIGHZ every pad enable is forced off. Under every other instruction the pads follow the core.

Top module: `jtag_bscan_tap`

## Requirements
- R1: The controller follows the standard 16-state TAP graph on TMS at the rising TCK edge. From any state, five rising edges with TMS high reach Test-Logic-Reset, and TMS high holds it there. Driving por_n low forces Test-Logic-Reset at any time, since no test-reset pin exists.
- R2: In Capture-IR the instruction shift stage loads 4'b0001, which Shift-IR sends out least significant bit first.
- R3: After power-on reset, and on every entry to Test-Logic-Reset, the active instruction is IDCODE. Its data path is 32 bits, shifted out LSB first, and bit 0 is 1.
- R4: The opcodes are 4'b0000 EXTEST, 4'b0010 SAMPLE/PRELOAD, 4'b0011 IDCODE, 4'b0101 HIGHZ and 4'b1111 BYPASS. Any other opcode behaves as BYPASS. The active instruction changes only in Update-IR or Test-Logic-Reset.
- R5: Under BYPASS a one-bit path captures 0, so each TDI bit appears at TDO one shift later.
- R6: Under SAMPLE/PRELOAD or EXTEST, Capture-DR loads the boundary chain. Bit 0 lies nearest TDO. For pad i, bit 3i is pin_in[i], bit 3i+1 is core_out[i] and bit 3i+2 is core_oe[i]. Bit 3*NPIN+j is cell_obs[j].
- R7: Under SAMPLE/PRELOAD or EXTEST, Update-DR copies chain bits 3i+1 and 3i+2 into pad i's value and enable update stages. Under SAMPLE/PRELOAD the pads still follow the core.
- R8: Under EXTEST, pad_out and pad_oe come from the update stages, and core changes do not reach the pads.
- R9: Under HIGHZ every pad_oe bit is 0, pad_out follows core_out, and the data path is the bypass bit.
- R10: TDO changes only on the falling TCK edge. tdo_oe is high only while the controller is in Shift-IR or Shift-DR.
- R11: Under IDCODE, BYPASS and unknown opcodes, pad_out equals core_out and pad_oe equals core_oe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tdo | output | 1 | Serial test data out, valid when tdo_oe is high |
| tdo_oe | output | 1 | TDO driver enable |
| core_out | input | NPIN | Core output value per pad |
| core_oe | input | NPIN | Core output enable per pad |
| pin_in | input | NPIN | Value seen at each pad |
| cell_obs | input | NCELL | Internal logic-cell signals to observe |
| pad_out | output | NPIN | Value driven to each pad |
| pad_oe | output | NPIN | Enable of each pad driver |

## Verification
The bench uses NPIN=4, NCELL=2 and identification value 32'h4D2C_A0B3. The 14-bit chain therefore holds both cell kinds, and one scan both captures every bit and preloads distinct value and enable patterns. With these widths the bench can check each chain position, the preload-then-EXTEST ordering, the five-edge TMS reset from inside Shift-DR, and a power-on reset taken while EXTEST drives the pads.

// File: rtl/jtag_bscan_pkg.sv
package jtag_bscan_pkg;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    localparam int unsigned IR_W = 4;
    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;
    localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0010;
    localparam logic [IR_W-1:0] OP_IDCODE  = 4'b0011;
    localparam logic [IR_W-1:0] OP_HIGHZ   = 4'b0101;
    localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;

    typedef enum logic [1:0] {DR_BYPASS, DR_IDCODE, DR_BOUNDARY} dr_sel_e;

    typedef struct packed {
        dr_sel_e sel;
        logic    drive;
        logic    all_off;
    } op_ctl_t;

    function automatic tap_state_e tap_next(tap_state_e s, logic m);
        tap_state_e n;
        case (s)
            ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
            ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
            default:   n = ST_RESET;
        endcase
        return n;
    endfunction

    function automatic op_ctl_t op_decode(logic [IR_W-1:0] op);
        op_ctl_t c;
        c = '{sel: DR_BYPASS, drive: 1'b0, all_off: 1'b0};
        case (op)
            OP_EXTEST: begin c.sel = DR_BOUNDARY; c.drive = 1'b1; end
            OP_SAMPLE: c.sel = DR_BOUNDARY;
            OP_IDCODE: c.sel = DR_IDCODE;
            OP_HIGHZ:  c.all_off = 1'b1;
            default:   c.sel = DR_BYPASS;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
    import jtag_bscan_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_e state_o
);
    typedef struct packed {
        tap_state_e st;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d    = ctrl_q;
        ctrl_d.st = tap_next(ctrl_q.st, tms);
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) ctrl_q <= '{st: ST_RESET};
        else        ctrl_q <= ctrl_d;
    end

    assign state_o = ctrl_q.st;
endmodule

// File: rtl/jtag_instr_reg.sv
module jtag_instr_reg
    import jtag_bscan_pkg::*;
(
    input  logic            tck,
    input  logic            por_n,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] instr_o,
    output logic            so
);
    typedef struct packed {
        logic [IR_W-1:0] sr;
        logic [IR_W-1:0] ir;
    } ir_t;

    ir_t ir_d, ir_q;

    always_comb begin
        ir_d = ir_q;
        case (state)
            ST_RESET:  ir_d.ir = OP_IDCODE;
            ST_CAP_IR: ir_d.sr = IR_CAPTURE;
            ST_SH_IR:  ir_d.sr = {tdi, ir_q.sr[IR_W-1:1]};
            ST_UPD_IR: ir_d.ir = ir_q.sr;
            default:   ;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) ir_q <= '{sr: IR_CAPTURE, ir: OP_IDCODE};
        else        ir_q <= ir_d;
    end

    assign instr_o = ir_q.ir;
    assign so      = ir_q.sr[0];
endmodule

// File: rtl/jtag_bscan_chain.sv
module jtag_bscan_chain
    import jtag_bscan_pkg::*;
#(
    parameter int unsigned NPIN  = 4,
    parameter int unsigned NCELL = 2
) (
    input  logic             tck,
    input  logic             por_n,
    input  tap_state_e       state,
    input  logic             sel,
    input  logic             drive,
    input  logic             all_off,
    input  logic             tdi,
    input  logic [NPIN-1:0]  pin_in,
    input  logic [NPIN-1:0]  core_out,
    input  logic [NPIN-1:0]  core_oe,
    input  logic [NCELL-1:0] cell_obs,
    output logic             so,
    output logic [NPIN-1:0]  pad_out,
    output logic [NPIN-1:0]  pad_oe
);
    localparam int unsigned LEN       = 3 * NPIN + NCELL;
    localparam int unsigned CELL_BASE = 3 * NPIN;

    typedef struct packed {
        logic [LEN-1:0]  sr;
        logic [NPIN-1:0] upd_dat;
        logic [NPIN-1:0] upd_oe;
    } chain_t;

    chain_t ch_d, ch_q;
    logic [LEN-1:0]  cap_vec;
    logic [NPIN-1:0] sr_dat, sr_oe;

    for (genvar i = 0; i < NPIN; i++) begin : g_pad
        assign cap_vec[3*i]   = pin_in[i];
        assign cap_vec[3*i+1] = core_out[i];
        assign cap_vec[3*i+2] = core_oe[i];
        assign sr_dat[i]      = ch_q.sr[3*i+1];
        assign sr_oe[i]       = ch_q.sr[3*i+2];
        assign pad_out[i]     = drive ? ch_q.upd_dat[i] : core_out[i];
        assign pad_oe[i]      = all_off ? 1'b0 : (drive ? ch_q.upd_oe[i] : core_oe[i]);
    end

    for (genvar j = 0; j < NCELL; j++) begin : g_cell
        assign cap_vec[CELL_BASE+j] = cell_obs[j];
    end

    always_comb begin
        ch_d = ch_q;
        if (sel) begin
            case (state)
                ST_CAP_DR: ch_d.sr = cap_vec;
                ST_SH_DR:  ch_d.sr = {tdi, ch_q.sr[LEN-1:1]};
                ST_UPD_DR: begin
                    ch_d.upd_dat = sr_dat;
                    ch_d.upd_oe  = sr_oe;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign so = ch_q.sr[0];
endmodule

// File: rtl/jtag_bscan_tap.sv
module jtag_bscan_tap
    import jtag_bscan_pkg::*;
#(
    parameter int unsigned NPIN       = 4,
    parameter int unsigned NCELL      = 2,
    parameter logic [31:0] IDCODE_VAL = 32'h4D2C_A0B3
) (
    input  logic             tck,
    input  logic             tms,
    input  logic             tdi,
    input  logic             por_n,
    output logic             tdo,
    output logic             tdo_oe,
    input  logic [NPIN-1:0]  core_out,
    input  logic [NPIN-1:0]  core_oe,
    input  logic [NPIN-1:0]  pin_in,
    input  logic [NCELL-1:0] cell_obs,
    output logic [NPIN-1:0]  pad_out,
    output logic [NPIN-1:0]  pad_oe
);
    localparam int unsigned ID_W = 32;

    tap_state_e      state;
    logic [IR_W-1:0] instr;
    logic            ir_so, bsr_so, dr_so;
    op_ctl_t         ctl;

    assign ctl = op_decode(instr);

    jtag_tap_ctrl u_ctrl (
        .tck(tck), .por_n(por_n), .tms(tms), .state_o(state)
    );

    jtag_instr_reg u_ir (
        .tck(tck), .por_n(por_n), .state(state), .tdi(tdi),
        .instr_o(instr), .so(ir_so)
    );

    jtag_bscan_chain #(.NPIN(NPIN), .NCELL(NCELL)) u_chain (
        .tck(tck), .por_n(por_n), .state(state),
        .sel(ctl.sel == DR_BOUNDARY), .drive(ctl.drive), .all_off(ctl.all_off),
        .tdi(tdi), .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
        .cell_obs(cell_obs), .so(bsr_so), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    typedef struct packed {
        logic            byp;
        logic [ID_W-1:0] id;
    } dr_t;

    typedef struct packed {
        logic tdo;
        logic oe;
    } out_t;

    dr_t  dr_d, dr_q;
    out_t out_d, out_q;

    always_comb begin
        dr_d = dr_q;
        case (state)
            ST_CAP_DR: begin
                if (ctl.sel == DR_BYPASS) dr_d.byp = 1'b0;
                if (ctl.sel == DR_IDCODE) dr_d.id  = IDCODE_VAL;
            end
            ST_SH_DR: begin
                if (ctl.sel == DR_BYPASS) dr_d.byp = tdi;
                if (ctl.sel == DR_IDCODE) dr_d.id  = {tdi, dr_q.id[ID_W-1:1]};
            end
            default: ;
        endcase
    end

    always_comb begin
        case (ctl.sel)
            DR_IDCODE:   dr_so = dr_q.id[0];
            DR_BOUNDARY: dr_so = bsr_so;
            default:     dr_so = dr_q.byp;
        endcase
    end

    always_comb begin
        out_d    = out_q;
        out_d.oe = (state == ST_SH_DR) || (state == ST_SH_IR);
        if (state == ST_SH_IR)     out_d.tdo = ir_so;
        else if (state == ST_SH_DR) out_d.tdo = dr_so;
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) dr_q <= '0;
        else        dr_q <= dr_d;
    end

    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign tdo    = out_q.tdo;
    assign tdo_oe = out_q.oe;
endmodule

// File: rtl/jtag_bscan_chk.sv
module jtag_bscan_chk
    import jtag_bscan_pkg::*;
#(
    parameter int unsigned NPIN = 4
) (
    input logic            tck,
    input logic            por_n,
    input logic            tms,
    input tap_state_e      state,
    input logic [IR_W-1:0] instr,
    input logic [NPIN-1:0] core_out,
    input logic [NPIN-1:0] core_oe,
    input logic [NPIN-1:0] pad_out,
    input logic [NPIN-1:0] pad_oe,
    input logic            tdo_oe
);
    a_r1_reset_hold: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_RESET && tms) |=> state == ST_RESET);

    a_r3_idcode_on_reset: assert property (@(posedge tck) disable iff (!por_n)
        state == ST_RESET |=> instr == OP_IDCODE);

    a_r4_instr_stable: assert property (@(posedge tck) disable iff (!por_n)
        (state != ST_UPD_IR && state != ST_RESET) |=> $stable(instr));

    a_r9_highz_off: assert property (@(posedge tck) disable iff (!por_n)
        instr == OP_HIGHZ |-> (pad_oe == '0 && pad_out == core_out));

    a_r10_tdo_oe_shift: assert property (@(posedge tck) disable iff (!por_n)
        tdo_oe == (state == ST_SH_DR || state == ST_SH_IR));

    a_r11_core_path: assert property (@(posedge tck) disable iff (!por_n)
        (instr != OP_EXTEST && instr != OP_HIGHZ) |-> (pad_out == core_out && pad_oe == core_oe));
endmodule

bind jtag_bscan_tap jtag_bscan_chk #(.NPIN(NPIN)) u_chk (
    .tck(tck), .por_n(por_n), .tms(tms), .state(state), .instr(instr),
    .core_out(core_out), .core_oe(core_oe), .pad_out(pad_out), .pad_oe(pad_oe),
    .tdo_oe(tdo_oe)
);

// File: tb/jtag_bscan_tap_tb.sv
module jtag_bscan_tap_tb;
    localparam int NPIN  = 4;
    localparam int NCELL = 2;
    localparam int LEN   = 3 * NPIN + NCELL;
    localparam logic [31:0] ID = 32'h4D2C_A0B3;

    logic tck = 1'b0, tms = 1'b1, tdi = 1'b0, por_n = 1'b0;
    logic tdo, tdo_oe;
    logic [NPIN-1:0]  core_out, core_oe, pin_in, pad_out, pad_oe;
    logic [NCELL-1:0] cell_obs;

    always #5 tck = ~tck;

    jtag_bscan_tap #(.NPIN(NPIN), .NCELL(NCELL), .IDCODE_VAL(ID)) u_dut (
        .tck(tck), .tms(tms), .tdi(tdi), .por_n(por_n), .tdo(tdo), .tdo_oe(tdo_oe),
        .core_out(core_out), .core_oe(core_oe), .pin_in(pin_in), .cell_obs(cell_obs),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    int  n_chk = 0, n_bad = 0;
    bit  done = 1'b0;
    logic last_oe;

    typedef struct {
        string       tag;
        int          w;
        logic [63:0] v;
    } exp_t;

    exp_t        exp_q[$];
    logic [63:0] act_v;
    event        got;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    // monitor: pops the next expected scan result and compares
    initial begin
        forever begin
            @(got);
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL scoreboard empty act=%h exp=none", act_v);
            end else begin
                exp_t e;
                logic [63:0] m;
                e = exp_q.pop_front();
                m = (64'd1 << e.w) - 64'd1;
                chk(e.tag, act_v & m, e.v & m);
            end
        end
    end

    task automatic step(input logic m, input logic i, output logic o);
        @(negedge tck);
        #1; tms = m; tdi = i;
        #3; o = tdo; last_oe = tdo_oe;
        @(posedge tck);
    endtask

    task automatic shift_body(input int w, input logic [63:0] din, output logic [63:0] dout,
                              output int oe_low);
        logic o;
        dout = '0; oe_low = 0;
        for (int k = 0; k < w; k++) begin
            step(k == w - 1, din[k], o);
            dout[k] = o;
            if (!last_oe) oe_low++;
        end
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
    endtask

    task automatic scan_dr(input string tag, input int w, input logic [63:0] din,
                           input logic [63:0] exp);
        logic o; logic [63:0] dout; int oe_low;
        exp_q.push_back('{tag: tag, w: w, v: exp});
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
        shift_body(w, din, dout, oe_low);
        act_v = dout; ->got;
        chk({tag, " / R10 tdo_oe low during Shift-DR"}, oe_low, 0);
    endtask

    task automatic scan_ir(input logic [3:0] op);
        logic o; logic [63:0] dout; int oe_low;
        exp_q.push_back('{tag: "R2 Capture-IR pattern 0001", w: 4, v: 64'h1});
        step(1'b1, 1'b0, o);
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
        shift_body(4, {60'd0, op}, dout, oe_low);
        act_v = dout; ->got;
    endtask

    function automatic logic [63:0] cap_exp();
        logic [63:0] v = '0;
        for (int i = 0; i < NPIN; i++) begin
            v[3*i] = pin_in[i]; v[3*i+1] = core_out[i]; v[3*i+2] = core_oe[i];
        end
        for (int j = 0; j < NCELL; j++) v[3*NPIN+j] = cell_obs[j];
        return v;
    endfunction

    function automatic logic [63:0] mk_pre(input logic [NPIN-1:0] dat, input logic [NPIN-1:0] oe);
        logic [63:0] v = '0;
        for (int i = 0; i < NPIN; i++) begin
            v[3*i+1] = dat[i]; v[3*i+2] = oe[i];
        end
        return v;
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic o;
        core_out = 4'b1010; core_oe = 4'b0110; pin_in = 4'b0011; cell_obs = 2'b10;
        repeat (3) @(posedge tck);
        @(negedge tck); por_n = 1'b1;
        #2;
        chk("R10 tdo_oe low after power-on", tdo_oe, 0);
        chk("R11 pad_out follows core after power-on", pad_out, core_out);
        chk("R11 pad_oe follows core after power-on", pad_oe, core_oe);
        step(1'b0, 1'b0, o);

        scan_dr("R3 IDCODE selected after power-on", 32, 64'd0, ID);

        scan_ir(4'b1111);
        scan_dr("R5 bypass delays TDI by one bit", 8, 64'hB2, 64'hB2 << 1);

        scan_ir(4'b1010);
        scan_dr("R4 unknown opcode acts as bypass", 6, 64'h35, 64'h35 << 1);
        chk("R11 pads follow core under unknown opcode", {pad_oe, pad_out}, {core_oe, core_out});

        scan_ir(4'b0010);
        scan_dr("R6 SAMPLE capture order", LEN, mk_pre(4'b0101, 4'b1111), cap_exp());
        #2;
        chk("R7 pads still follow core after preload", {pad_oe, pad_out}, {core_oe, core_out});

        scan_ir(4'b0000);
        #2;
        chk("R8 EXTEST drives preloaded value", pad_out, 4'b0101);
        chk("R8 EXTEST drives preloaded enable", pad_oe, 4'b1111);
        core_out = 4'b0110; core_oe = 4'b0001;
        #2;
        chk("R8 core change ignored under EXTEST", {pad_oe, pad_out}, {4'b1111, 4'b0101});

        pin_in = 4'b1100; cell_obs = 2'b01;
        scan_dr("R6 EXTEST capture order", LEN, mk_pre(4'b0011, 4'b1001), cap_exp());
        #2;
        chk("R7 R8 update-DR loads new pad value", pad_out, 4'b0011);
        chk("R7 R8 update-DR loads new pad enable", pad_oe, 4'b1001);

        scan_ir(4'b0101);
        #2;
        chk("R9 HIGHZ forces every enable off", pad_oe, 4'b0000);
        chk("R9 HIGHZ pad value follows core", pad_out, core_out);
        scan_dr("R9 HIGHZ uses bypass bit", 5, 64'h13, 64'h13 << 1);

        scan_ir(4'b0011);
        scan_dr("R4 IDCODE opcode selects identification", 32, 64'hFFFF_FFFF, ID);

        // R10: TDO moves only at the falling edge
        scan_ir(4'b1111);
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b1, o);
        step(1'b0, 1'b1, o);
        chk("R10 first bypass bit is captured 0", o, 0);
        #1;
        chk("R10 tdo holds across rising edge", tdo, 0);
        @(negedge tck); #1;
        chk("R10 tdo updates on falling edge", tdo, 1);
        step(1'b1, 1'b0, o);
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);

        // R1: five TMS-high edges from inside Shift-DR
        scan_ir(4'b1111);
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        scan_dr("R1 five TMS-high edges reset, R3 IDCODE reselected", 32, 64'd0, ID);

        // R1: power-on reset while EXTEST drives pads
        scan_ir(4'b0000);
        #2;
        chk("R8 EXTEST drives held update stages", {pad_oe, pad_out}, {4'b1001, 4'b0011});
        @(negedge tck); por_n = 1'b0;
        #2;
        chk("R1 power-on reset returns pads to core", {pad_oe, pad_out}, {core_oe, core_out});
        chk("R1 R10 tdo_oe low during power-on reset", tdo_oe, 0);
        @(negedge tck); por_n = 1'b1;
        step(1'b0, 1'b0, o);
        scan_dr("R1 R3 IDCODE after mid-run power-on reset", 32, 64'd0, ID);

        repeat (2) @(posedge tck);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule